// File: doc/BRIEF.md
# Supply Brown-out Reset Sequencer

This block is the digital side of a supply monitor. An analog comparator, outside the block, reports whether the supply sits below the chosen threshold. The block first passes that asynchronous level through a two-flop synchroniser. It then decides from a two-bit policy code, a software enable bit and the sleep state whether low-supply detection is armed. While detection is armed and the supply is low, the block holds the device reset.

When the supply recovers, reset can be stretched by an optional power-up delay of `DELAY_CYC` clock cycles. A new dip during that delay sends the block back to the held state, and the whole delay starts again. Two sticky status flags record a power-on event and a brown-out event. Software reads these flags and clears them with write strobes. A power-on event also marks the brown-out flag, so software clears both flags after start-up and treats "brown-out set, power-on clear" as a real brown-out. The threshold select code is only forwarded to the comparator.

Top module: `sgc_top`

## Requirements
- R1: Policy code 2'b00 disarms detection: a low supply never raises `rst_o`, and the delay counter stays at 0, whatever the delay enable is.
- R2: Policy code 2'b01 arms detection exactly when the software enable register is 1. This register is written through `sw_wr_i`/`sw_data_i` and resets to 0. `sw_en_o` shows the register under code 2'b01 and reads 0 under every other code.
- R3: Policy code 2'b10 arms detection while `sleep_i` is 0 and disarms it while `sleep_i` is 1.
- R4: Policy code 2'b11 arms detection at all times, including sleep, and the software enable register has no effect.
- R5: With detection armed, `rst_o` rises at the third rising clock edge after `vlow_i` goes high. It stays high while the synchronised supply-low level persists.
- R6: With `pwrt_en_i`=0, `rst_o` falls at the third edge after `vlow_i` falls. With `pwrt_en_i`=1, it falls at edge 3+`DELAY_CYC`, while `delay_cnt_o` counts 0,1,2,... from edge 3.
- R7: A supply-low level that reaches the sequencer during the delay returns it to the held state, sets `delay_cnt_o` to 0 and sets the brown-out flag. After recovery the full delay runs again.
- R8: Each entry into the held state sets `bor_flag_o` at the same edge that raises `rst_o`. It leaves `por_flag_o` unchanged.
- R9: A one-cycle pulse on `por_evt_i` or on `dsleep_exit_i` sets both `por_flag_o` and `bor_flag_o` at the next edge.
- R10: `clr_por_i` / `clr_bor_i` clear their flag at the next edge. A set condition in the same cycle wins over the clear.
- R11: After `rst_n` is released, `rst_o`=0, `delay_cnt_o`=0, `sw_en_o`=0 and both flags are 1. `thr_sel_o` always equals `thr_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlow_i | input | 1 | Comparator level, 1 = supply below threshold (asynchronous) |
| en_cfg_i | input | 2 | Detection policy code |
| sw_wr_i | input | 1 | Write strobe for the software enable register |
| sw_data_i | input | 1 | Value written to the software enable register |
| sleep_i | input | 1 | Device is in sleep |
| pwrt_en_i | input | 1 | Enables the power-up delay |
| por_evt_i | input | 1 | Power-on event pulse |
| dsleep_exit_i | input | 1 | Deep-sleep exit pulse |
| clr_por_i | input | 1 | Clears the power-on flag |
| clr_bor_i | input | 1 | Clears the brown-out flag |
| thr_sel_i | input | 2 | Threshold select code |
| thr_sel_o | output | 2 | Threshold select forwarded to the comparator |
| rst_o | output | 1 | Device reset, active high |
| delay_cnt_o | output | CW | Power-up delay counter |
| sw_en_o | output | 1 | Software enable read-back |
| por_flag_o | output | 1 | Power-on status flag |
| bor_flag_o | output | 1 | Brown-out status flag |

## Verification
The hardest case to reach is a dip that arrives in the middle of the power-up delay. The restart is only visible if the new low level gets through the synchroniser while the counter is part-way through its count, and not at its last step. The bench releases the supply and waits until `delay_cnt_o` is mid-count. It then raises `vlow_i` again and checks at the exact edge that the counter is back at 0, that reset is still held and that the brown-out flag was set again. After that it times a complete second delay. The set-over-clear priority is reached by driving a clear strobe in the same cycle as an event pulse.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } sgc_state_e;

  localparam logic [1:0] POL_OFF    = 2'b00;
  localparam logic [1:0] POL_SW     = 2'b01;
  localparam logic [1:0] POL_AWAKE  = 2'b10;
  localparam logic [1:0] POL_ALWAYS = 2'b11;

  localparam int FLAG_POR = 0;
  localparam int FLAG_BOR = 1;
  localparam int NFLAGS   = 2;
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sgc_enable.sv
module sgc_enable
  import sgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_cfg_i,
  input  logic       sleep_i,
  input  logic       sw_wr_i,
  input  logic       sw_data_i,
  output logic       det_en_o,
  output logic       sw_rd_o
);
  logic sw_q, sw_d;

  always_comb begin
    sw_d = sw_q;
    if (sw_wr_i) sw_d = sw_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_q <= 1'b0;
    else if (sw_wr_i) sw_q <= sw_d;
  end

  always_comb begin
    det_en_o = 1'b0;
    sw_rd_o  = 1'b0;
    unique case (en_cfg_i)
      POL_OFF:    det_en_o = 1'b0;
      POL_SW:     begin det_en_o = sw_q; sw_rd_o = sw_q; end
      POL_AWAKE:  det_en_o = ~sleep_i;
      POL_ALWAYS: det_en_o = 1'b1;
      default:    det_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sgc_seq.sv
module sgc_seq
  import sgc_pkg::*;
#(
  parameter int DELAY_CYC = 64,
  localparam int CW = $clog2(DELAY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_en_i,
  input  logic          low_i,
  input  logic          pwrt_en_i,
  output logic          hold_o,
  output logic [CW-1:0] cnt_o,
  output logic          entry_o
);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  sgc_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ld;
  logic          trip;

  assign trip = det_en_i & low_i;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    entry_o = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        cnt_d = '0;
        if (trip) begin
          st_d    = ST_HOLD;
          entry_o = 1'b1;
        end
      end
      ST_HOLD: begin
        cnt_d = '0;
        if (!trip) st_d = pwrt_en_i ? ST_WAIT : ST_RUN;
      end
      ST_WAIT: begin
        if (trip) begin
          st_d    = ST_HOLD;
          cnt_d   = '0;
          entry_o = 1'b1;
        end else if (cnt_q == LAST) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_HOLD;
        cnt_d = '0;
      end
    endcase
  end

  assign cnt_ld = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign hold_o = (st_q != ST_RUN);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sgc_flags.sv
module sgc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d, flag_en;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_comb begin
        flag_en[i] = set_i[i] | clr_i[i];
        flag_d[i]  = set_i[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q[i] <= 1'b1;
        else if (flag_en[i]) flag_q[i] <= flag_d[i];
      end
    end
  endgenerate

  assign flag_o = flag_q;
endmodule

// File: rtl/sgc_top.sv
module sgc_top
  import sgc_pkg::*;
#(
  parameter int DELAY_CYC = 64,
  localparam int CW = $clog2(DELAY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vlow_i,
  input  logic [1:0]    en_cfg_i,
  input  logic          sw_wr_i,
  input  logic          sw_data_i,
  input  logic          sleep_i,
  input  logic          pwrt_en_i,
  input  logic          por_evt_i,
  input  logic          dsleep_exit_i,
  input  logic          clr_por_i,
  input  logic          clr_bor_i,
  input  logic [1:0]    thr_sel_i,
  output logic [1:0]    thr_sel_o,
  output logic          rst_o,
  output logic [CW-1:0] delay_cnt_o,
  output logic          sw_en_o,
  output logic          por_flag_o,
  output logic          bor_flag_o
);
  logic              low_s;
  logic              det_en;
  logic              entry;
  logic [NFLAGS-1:0] fset, fclr, fq;

  sgc_sync #(.W(1), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(vlow_i), .q_o(low_s)
  );

  sgc_enable u_en (
    .clk(clk), .rst_n(rst_n), .en_cfg_i(en_cfg_i), .sleep_i(sleep_i),
    .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i),
    .det_en_o(det_en), .sw_rd_o(sw_en_o)
  );

  sgc_seq #(.DELAY_CYC(DELAY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .det_en_i(det_en), .low_i(low_s),
    .pwrt_en_i(pwrt_en_i), .hold_o(rst_o), .cnt_o(delay_cnt_o),
    .entry_o(entry)
  );

  always_comb begin
    fset[FLAG_POR] = por_evt_i | dsleep_exit_i;
    fset[FLAG_BOR] = entry | por_evt_i | dsleep_exit_i;
    fclr[FLAG_POR] = clr_por_i;
    fclr[FLAG_BOR] = clr_bor_i;
  end

  sgc_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(fclr), .flag_o(fq)
  );

  assign por_flag_o = fq[FLAG_POR];
  assign bor_flag_o = fq[FLAG_BOR];
  assign thr_sel_o  = thr_sel_i;
endmodule

// File: rtl/sgc_chk.sv
module sgc_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          det_en,
  input logic          low_s,
  input logic          rst_o,
  input logic [CW-1:0] delay_cnt_o,
  input logic          por_flag_o,
  input logic          bor_flag_o,
  input logic          por_evt_i,
  input logic          dsleep_exit_i,
  input logic          clr_por_i
);
  // R5
  rise_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(det_en && low_s));

  // R6
  count_only_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_cnt_o != '0) |-> rst_o);

  // R7
  count_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_cnt_o != '0) |-> (delay_cnt_o == $past(delay_cnt_o) + 1'b1));

  // R8
  bor_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> bor_flag_o);

  // R9
  dsleep_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsleep_exit_i |=> (por_flag_o && bor_flag_o));

  // R10
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_por_i && !por_evt_i && !dsleep_exit_i) |=> !por_flag_o);
endmodule

bind sgc_top sgc_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .low_s(low_s), .rst_o(rst_o),
  .delay_cnt_o(delay_cnt_o), .por_flag_o(por_flag_o), .bor_flag_o(bor_flag_o),
  .por_evt_i(por_evt_i), .dsleep_exit_i(dsleep_exit_i), .clr_por_i(clr_por_i)
);

// File: tb/test_sgc_top.sv
module test_sgc_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 8;
  localparam int CW         = $clog2(DLY + 1);
  localparam int NVEC       = 9;
  // {cfg[1:0], sw, sleep, expected rst}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00_1_0_0, 5'b00_0_1_0, 5'b01_1_0_1, 5'b01_0_0_0, 5'b01_1_1_1,
    5'b10_0_0_1, 5'b10_0_1_0, 5'b11_0_1_1, 5'b11_1_0_1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vlow = 0, sw_wr = 0, sw_data = 0, sleep = 0, pwrt = 0;
  logic por_evt = 0, ds_exit = 0, clr_por = 0, clr_bor = 0;
  logic [1:0] cfg = 2'b00, thr_i = 2'b00, thr_o;
  logic rst_o, sw_en_o, por_f, bor_f;
  logic [CW-1:0] cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgc_top #(.DELAY_CYC(DLY)) i_sgc_top (
    .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .en_cfg_i(cfg),
    .sw_wr_i(sw_wr), .sw_data_i(sw_data), .sleep_i(sleep), .pwrt_en_i(pwrt),
    .por_evt_i(por_evt), .dsleep_exit_i(ds_exit), .clr_por_i(clr_por),
    .clr_bor_i(clr_bor), .thr_sel_i(thr_i), .thr_sel_o(thr_o), .rst_o(rst_o),
    .delay_cnt_o(cnt), .sw_en_o(sw_en_o), .por_flag_o(por_f), .bor_flag_o(bor_f)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input logic v);
    sw_data = v; sw_wr = 1'b1; cyc(1); sw_wr = 1'b0;
  endtask

  task automatic clear_flags();
    clr_por = 1'b1; clr_bor = 1'b1; cyc(1); clr_por = 1'b0; clr_bor = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    cyc(1000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    // R11 reset state
    check("R11", "rst_o", rst_o, 0);
    check("R11", "cnt", cnt, 0);
    check("R11", "sw_en_o", sw_en_o, 0);
    check("R11", "por", por_f, 1);
    check("R11", "bor", bor_f, 1);
    thr_i = 2'b10; #1;
    check("R11", "thr pass", thr_o, 2);

    // table walk over policy modes
    for (int i = 0; i < NVEC; i++) begin
      cfg = VEC[i][4:3]; sleep = VEC[i][1]; pwrt = 1'b0;
      sw_write(VEC[i][2]); cyc(1);
      check("R2", "sw readback", sw_en_o, (cfg == 2'b01) ? int'(VEC[i][2]) : 0);
      vlow = 1'b1; cyc(4);
      check(tag_of(cfg), "rst during low", rst_o, int'(VEC[i][0]));
      vlow = 1'b0; cyc(4);
      check(tag_of(cfg), "rst after recover", rst_o, 0);
    end

    // R5 exact rise edge, R8 flag behaviour
    cfg = 2'b11; sleep = 1'b0; pwrt = 1'b0; clear_flags();
    check("R10", "por cleared", por_f, 0);
    check("R10", "bor cleared", bor_f, 0);
    vlow = 1'b1; cyc(2);
    check("R5", "rst before 3rd edge", rst_o, 0);
    cyc(1);
    check("R5", "rst at 3rd edge", rst_o, 1);
    check("R8", "bor set on entry", bor_f, 1);
    check("R8", "por unchanged", por_f, 0);
    cyc(5);
    check("R5", "rst held", rst_o, 1);
    vlow = 1'b0; cyc(2);
    check("R6", "no-delay still held", rst_o, 1);
    cyc(1);
    check("R6", "no-delay released", rst_o, 0);

    // R6 power-up delay timing
    pwrt = 1'b1; vlow = 1'b1; cyc(4); vlow = 1'b0;
    cyc(3);
    check("R6", "cnt at entry", cnt, 0);
    cyc(7);
    check("R6", "last count", cnt, DLY - 1);
    check("R6", "held in delay", rst_o, 1);
    cyc(1);
    check("R6", "released after delay", rst_o, 0);
    check("R6", "cnt back to 0", cnt, 0);

    // R7 dip in the middle of the delay
    vlow = 1'b1; cyc(4); vlow = 1'b0; cyc(6);
    check("R7", "mid count", cnt, 3);
    clear_flags();
    vlow = 1'b1; cyc(2);
    check("R7", "still counting", cnt, 6);
    cyc(1);
    check("R7", "cnt restarted", cnt, 0);
    check("R7", "rst held", rst_o, 1);
    check("R7", "bor set again", bor_f, 1);
    vlow = 1'b0; cyc(10);
    check("R7", "full delay held", rst_o, 1);
    cyc(1);
    check("R7", "full delay released", rst_o, 0);

    // R1 with delay enabled: no reset, no count
    cfg = 2'b00; vlow = 1'b1; cyc(6);
    check("R1", "off rst", rst_o, 0);
    check("R1", "off cnt", cnt, 0);
    vlow = 1'b0; cyc(3);

    // R4 sleep in always mode, software bit 0
    cfg = 2'b11; sleep = 1'b1; pwrt = 1'b0; sw_write(1'b0);
    vlow = 1'b1; cyc(3);
    check("R4", "always in sleep", rst_o, 1);
    vlow = 1'b0; cyc(3);

    // R9 event pulses
    clear_flags();
    por_evt = 1'b1; cyc(1); por_evt = 1'b0;
    check("R9", "por evt por", por_f, 1);
    check("R9", "por evt bor", bor_f, 1);
    clear_flags();
    ds_exit = 1'b1; cyc(1); ds_exit = 1'b0;
    check("R9", "dsleep por", por_f, 1);
    check("R9", "dsleep bor", bor_f, 1);

    // R10 set wins over clear
    clear_flags();
    ds_exit = 1'b1; clr_por = 1'b1; clr_bor = 1'b1; cyc(1);
    ds_exit = 1'b0; clr_por = 1'b0; clr_bor = 1'b0;
    check("R10", "set beats clr por", por_f, 1);
    check("R10", "set beats clr bor", bor_f, 1);
    clr_bor = 1'b1; cyc(1); clr_bor = 1'b0;
    check("R10", "bor clr only", bor_f, 0);
    check("R10", "por kept", por_f, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1;
    $finish;
  end
endmodule